// File: doc/BRIEF.md
# Memory Protection Access Checker

This block decides, for every bus access presented to it, whether the access may proceed and whether the target is marked execute-never. Software programs a small set of configuration registers: a control word with three switches (master enable, a background-map enable for privileged code, and a switch that keeps checking active inside the highest-priority fault handlers), a region-select register, and a base word and attribute word per region. The base and attribute words are reached through the region select.

Each access carries an address, a privilege flag, an access kind (read, write or instruction fetch) and a flag that says the processor is running at priority -1 or -2. The permit and execute-never results are combinational. A registered fault flag follows one cycle after each valid access. The system control space and the vector table are never blocked while checking is active. Outside the configured regions, privileged code may optionally fall back to the default map.

Top module: `mpu_chk`

## Requirements
- R1: Configuration is written when `cfg_we` is 1, to the register picked by `cfg_addr`: 0 control (bit0 enable, bit1 checking in top-priority handlers, bit2 privileged background), 1 region select, 2 base of the selected region (bits 31:5 kept, bits 4:0 read 0), 3 attributes of the selected region (bit0 enable, bits 5:1 size code N, bits 10:8 permission code, bit12 execute-never, other bits read 0). `cfg_rdata` returns the addressed register. All registers reset to 0.
- R2: With enable clear, every read and write is permitted for both privilege levels, and no region takes part in the decision.
- R3: A region is enabled, has N of at least 4, and covers 2^(N+1) bytes starting at its base, taken with the low N+1 bits ignored. N values below 4 never match.
- R4: When several enabled regions match, the highest-numbered region supplies the permission and the execute-never bit.
- R5: Permission codes (fetch counts as read): 0 none; 1 privileged read/write only; 2 privileged read/write, unprivileged read; 3 full; 5 privileged read only; 6 read only for both; 4 and 7 none. Access kind codes: 0 read, 1 write, 2 fetch (3 behaves as read).
- R6: With enable and background set, a privileged access that matches no region is permitted, and an unprivileged one faults.
- R7: With enable set and background clear, an access matching no region faults at either privilege level.
- R8: While `acc_negpri` is 1 and the handler-checking bit is 0, the block behaves as if enable were clear.
- R9: While checking is active, accesses to 0xE000E000..0xE000EFFF and to the vector table (VT_BASE up to VT_BASE+1023) are permitted regardless of regions and privilege.
- R10: Execute-never is the matching region's bit when a region decides the access. Otherwise it is 1 for addresses at or above 0xE0000000, and always 1 in 0xE000E000..0xE000EFFF, enabled or not. A fetch with execute-never set is not permitted.
- R11: `acc_fault_q` is 1 in the cycle after a valid access whose permit was 0, and 0 after any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| acc_valid | input | 1 | Access present |
| acc_addr | input | 32 | Access address |
| acc_priv | input | 1 | Access is privileged |
| acc_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| acc_negpri | input | 1 | Executing at priority -1 or -2 |
| acc_permit | output | 1 | Access allowed (combinational) |
| acc_xn | output | 1 | Execute-never attribute (combinational) |
| acc_fault_q | output | 1 | Registered fault, one cycle after the access |

## Verification
Permit and execute-never are combinational, so the bench drives an access on a falling edge and samples both 1 ns later, in the same cycle. The fault flag passes through one register. It is sampled just after the next rising edge and compared with the inverse of the permit predicted for the previous access. Configuration writes land on a rising edge and reads are combinational, so readback is sampled in the cycle after the write. After reset is released the bench waits for the two-stage reset synchronizer before its first check.

// File: rtl/mpu_chk_pkg.sv
package mpu_chk_pkg;

  localparam int unsigned AP_W = 3;
  localparam int unsigned SZ_W = 5;
  localparam logic [SZ_W-1:0] SZ_MIN = 5'd4;

  localparam logic [1:0] CFG_CTRL = 2'd0;
  localparam logic [1:0] CFG_SEL  = 2'd1;
  localparam logic [1:0] CFG_BASE = 2'd2;
  localparam logic [1:0] CFG_ATTR = 2'd3;

  localparam logic [1:0] KIND_WR = 2'd1;
  localparam logic [1:0] KIND_EX = 2'd2;

  typedef struct packed {
    logic            xn;
    logic [AP_W-1:0] ap;
    logic [SZ_W-1:0] sz;
    logic            en;
  } rgn_attr_t;

  function automatic logic ap_allows(input logic [AP_W-1:0] ap, input logic priv,
                                     input logic is_wr);
    logic ok;
    case (ap)
      3'd1:    ok = priv;
      3'd2:    ok = priv | ~is_wr;
      3'd3:    ok = 1'b1;
      3'd5:    ok = priv & ~is_wr;
      3'd6:    ok = ~is_wr;
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/mpu_cfg_regs.sv
module mpu_cfg_regs
  import mpu_chk_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [1:0]             cfg_addr,
  input  logic [31:0]            cfg_wdata,
  output logic [31:0]            cfg_rdata,
  output logic                   ctrl_en,
  output logic                   ctrl_hfn,
  output logic                   ctrl_bg,
  output logic [NREG-1:0][31:0]  rgn_base,
  output rgn_attr_t [NREG-1:0]   rgn_attr
);

  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic [2:0]       ctrl_q, ctrl_d;
  logic [IDX_W-1:0] sel_q, sel_d;
  logic             unused_wbits;

  assign unused_wbits = ^{cfg_wdata[31:13], cfg_wdata[11], cfg_wdata[7:6]};

  always_comb begin
    ctrl_d = ctrl_q;
    sel_d  = sel_q;
    if (cfg_we && cfg_addr == CFG_CTRL) ctrl_d = cfg_wdata[2:0];
    if (cfg_we && cfg_addr == CFG_SEL)  sel_d  = cfg_wdata[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sel_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      sel_q  <= sel_d;
    end
  end

  for (genvar gi = 0; gi < NREG; gi++) begin : g_rgn
    logic [26:0] base_q, base_d;
    rgn_attr_t   attr_q, attr_d;
    logic        pick;

    assign pick = cfg_we && (int'(sel_q) == gi);

    always_comb begin
      base_d = base_q;
      attr_d = attr_q;
      if (pick && cfg_addr == CFG_BASE) base_d = cfg_wdata[31:5];
      if (pick && cfg_addr == CFG_ATTR) begin
        attr_d.en = cfg_wdata[0];
        attr_d.sz = cfg_wdata[5:1];
        attr_d.ap = cfg_wdata[10:8];
        attr_d.xn = cfg_wdata[12];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
        attr_q <= '0;
      end else begin
        base_q <= base_d;
        attr_q <= attr_d;
      end
    end

    assign rgn_base[gi] = {base_q, 5'b0};
    assign rgn_attr[gi] = attr_q;
  end

  assign ctrl_en  = ctrl_q[0];
  assign ctrl_hfn = ctrl_q[1];
  assign ctrl_bg  = ctrl_q[2];

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      CFG_CTRL: cfg_rdata = {29'b0, ctrl_q};
      CFG_SEL:  cfg_rdata = {{(32-IDX_W){1'b0}}, sel_q};
      CFG_BASE: if (int'(sel_q) < NREG) cfg_rdata = rgn_base[sel_q];
      default:  if (int'(sel_q) < NREG)
                  cfg_rdata = {19'b0, rgn_attr[sel_q].xn, 1'b0, rgn_attr[sel_q].ap,
                               2'b0, rgn_attr[sel_q].sz, rgn_attr[sel_q].en};
    endcase
  end

endmodule

// File: rtl/mpu_rgn_match.sv
module mpu_rgn_match
  import mpu_chk_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic [31:0]           addr,
  input  logic [NREG-1:0][31:0] rgn_base,
  input  rgn_attr_t [NREG-1:0]  rgn_attr,
  output logic [NREG-1:0]       hit
);

  for (genvar gi = 0; gi < NREG; gi++) begin : g_m
    logic [31:0] low_mask;
    always_comb begin
      if (rgn_attr[gi].sz == 5'd31) low_mask = '1;
      else low_mask = (32'd1 << (rgn_attr[gi].sz + 5'd1)) - 32'd1;
    end
    assign hit[gi] = rgn_attr[gi].en && (rgn_attr[gi].sz >= SZ_MIN) &&
                     (((addr ^ rgn_base[gi]) & ~low_mask) == 32'd0);
  end

endmodule

// File: rtl/mpu_decide.sv
module mpu_decide
  import mpu_chk_pkg::*;
#(
  parameter int          NREG    = 8,
  parameter logic [31:0] VT_BASE = 32'h0000_0000,
  parameter logic [31:0] SCS_LO  = 32'hE000_E000,
  parameter logic [31:0] SCS_HI  = 32'hE000_EFFF
) (
  input  logic                       ctrl_en,
  input  logic                       ctrl_hfn,
  input  logic                       ctrl_bg,
  input  logic [31:0]                addr,
  input  logic                       priv,
  input  logic [1:0]                 kind,
  input  logic                       negpri,
  input  logic [NREG-1:0]            hit,
  input  logic [NREG-1:0][AP_W-1:0]  rgn_ap,
  input  logic [NREG-1:0]            rgn_xn,
  output logic                       permit,
  output logic                       xn
);

  localparam logic [32:0] VT_END = {1'b0, VT_BASE} + 33'd1024;

  logic            is_scs, is_vt, dflt_xn, checking, any_hit, ok;
  logic [AP_W-1:0] win_ap;
  logic            win_xn;

  assign is_scs   = (addr >= SCS_LO) && (addr <= SCS_HI);
  assign is_vt    = (addr >= VT_BASE) && ({1'b0, addr} < VT_END);
  assign dflt_xn  = (addr[31:29] == 3'b111);
  assign checking = ctrl_en && (!negpri || ctrl_hfn);

  always_comb begin
    any_hit = 1'b0;
    win_ap  = '0;
    win_xn  = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      if (hit[i]) begin
        any_hit = 1'b1;
        win_ap  = rgn_ap[i];
        win_xn  = rgn_xn[i];
      end
    end
  end

  always_comb begin
    ok = 1'b1;
    xn = dflt_xn | is_scs;
    if (checking && !is_scs && !is_vt) begin
      if (any_hit) begin
        xn = win_xn;
        ok = ap_allows(win_ap, priv, kind == KIND_WR);
      end else begin
        ok = ctrl_bg && priv;
      end
    end
    permit = ok && !((kind == KIND_EX) && xn);
  end

endmodule

// File: rtl/mpu_chk.sv
module mpu_chk
  import mpu_chk_pkg::*;
#(
  parameter int          NREG    = 8,
  parameter logic [31:0] VT_BASE = 32'h0000_0000,
  parameter logic [31:0] SCS_LO  = 32'hE000_E000,
  parameter logic [31:0] SCS_HI  = 32'hE000_EFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        acc_valid,
  input  logic [31:0] acc_addr,
  input  logic        acc_priv,
  input  logic [1:0]  acc_kind,
  input  logic        acc_negpri,
  output logic        acc_permit,
  output logic        acc_xn,
  output logic        acc_fault_q
);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic                      ctrl_en, ctrl_hfn, ctrl_bg;
  logic [NREG-1:0][31:0]     rgn_base;
  rgn_attr_t [NREG-1:0]      rgn_attr;
  logic [NREG-1:0]           hit;
  logic [NREG-1:0][AP_W-1:0] rgn_ap;
  logic [NREG-1:0]           rgn_xn;
  logic                      flt_d, flt_q;

  mpu_cfg_regs #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ctrl_en(ctrl_en),
    .ctrl_hfn(ctrl_hfn), .ctrl_bg(ctrl_bg), .rgn_base(rgn_base), .rgn_attr(rgn_attr)
  );

  mpu_rgn_match #(.NREG(NREG)) u_match (
    .addr(acc_addr), .rgn_base(rgn_base), .rgn_attr(rgn_attr), .hit(hit)
  );

  for (genvar gi = 0; gi < NREG; gi++) begin : g_fld
    assign rgn_ap[gi] = rgn_attr[gi].ap;
    assign rgn_xn[gi] = rgn_attr[gi].xn;
  end

  mpu_decide #(.NREG(NREG), .VT_BASE(VT_BASE), .SCS_LO(SCS_LO), .SCS_HI(SCS_HI)) u_dec (
    .ctrl_en(ctrl_en), .ctrl_hfn(ctrl_hfn), .ctrl_bg(ctrl_bg), .addr(acc_addr),
    .priv(acc_priv), .kind(acc_kind), .negpri(acc_negpri), .hit(hit),
    .rgn_ap(rgn_ap), .rgn_xn(rgn_xn), .permit(acc_permit), .xn(acc_xn)
  );

  assign flt_d = acc_valid & ~acc_permit;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) flt_q <= 1'b0;
    else              flt_q <= flt_d;
  end
  assign acc_fault_q = flt_q;

endmodule

// File: rtl/mpu_chk_sva.sv
module mpu_chk_sva #(
  parameter logic [31:0] SCS_LO = 32'hE000_E000,
  parameter logic [31:0] SCS_HI = 32'hE000_EFFF
) (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic [31:0] acc_addr,
  input logic [1:0]  acc_kind,
  input logic        acc_negpri,
  input logic        acc_permit,
  input logic        acc_xn,
  input logic        acc_fault_q,
  input logic        ctrl_en,
  input logic        ctrl_hfn
);

  logic in_scs;
  assign in_scs = (acc_addr >= SCS_LO) && (acc_addr <= SCS_HI);

  AST_FAULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_permit) |=> acc_fault_q);                                // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid) |=> !acc_fault_q);                                             // R11
  AST_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && acc_kind != 2'd2) |-> acc_permit);                             // R2
  AST_HANDLER_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && acc_negpri && !ctrl_hfn && acc_kind != 2'd2) |-> acc_permit);   // R8
  AST_SCS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_scs && acc_kind != 2'd2) |-> acc_permit);                               // R9
  AST_SCS_XN: assert property (@(posedge clk) disable iff (!rst_n)
    in_scs |-> acc_xn);                                                         // R10
  AST_FETCH_XN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == 2'd2 && acc_xn) |-> !acc_permit);                              // R10

endmodule

bind mpu_chk mpu_chk_sva #(.SCS_LO(SCS_LO), .SCS_HI(SCS_HI)) u_sva (
  .clk(clk), .rst_n(rst_sync_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .acc_kind(acc_kind), .acc_negpri(acc_negpri), .acc_permit(acc_permit),
  .acc_xn(acc_xn), .acc_fault_q(acc_fault_q), .ctrl_en(ctrl_en), .ctrl_hfn(ctrl_hfn)
);

// File: tb/sim_mpu_chk.sv
`timescale 1ns/1ps
module sim_mpu_chk;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        acc_valid;
  logic [31:0] acc_addr;
  logic        acc_priv;
  logic [1:0]  acc_kind;
  logic        acc_negpri;
  logic        acc_permit, acc_xn, acc_fault_q;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] sh_base [8];
  bit          sh_en [8];
  int          sh_sz [8];
  int          sh_ap [8];
  bit          sh_xn [8];

  always #10 clk = ~clk;

  mpu_chk u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_priv(acc_priv),
    .acc_kind(acc_kind), .acc_negpri(acc_negpri), .acc_permit(acc_permit), .acc_xn(acc_xn),
    .acc_fault_q(acc_fault_q)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(cfg_rdata === exp, tag, cfg_rdata, exp);
  endtask

  function automatic logic [31:0] attr_word(bit en, int sz, int ap, bit xn);
    return (32'(en)) | (32'(sz) << 1) | (32'(ap) << 8) | (32'(xn) << 12);
  endfunction

  task automatic set_rgn(input int i, input logic [31:0] b, input bit en, input int sz,
                         input int ap, input bit xn);
    wr(2'd1, 32'(i));
    wr(2'd2, b);
    wr(2'd3, attr_word(en, sz, ap, xn));
    sh_base[i] = b; sh_en[i] = en; sh_sz[i] = sz; sh_ap[i] = ap; sh_xn[i] = xn;
  endtask

  function automatic bit ap_ok(int ap, bit priv, bit is_wr);
    if (ap == 3) return 1;
    if (ap == 1) return priv;
    if (ap == 2) return priv || !is_wr;
    if (ap == 5) return priv && !is_wr;
    if (ap == 6) return !is_wr;
    return 0;
  endfunction

  function automatic void ref_model(input logic [31:0] a, input bit priv, input int kind,
                                    input bit neg, input bit [2:0] ctl,
                                    output bit p, output bit x, output string tag);
    bit scs = (a >= 32'hE000E000) && (a <= 32'hE000EFFF);
    bit vt  = (a < 32'd1024);
    int w = -1;
    x = (a >= 32'hE0000000);
    p = 1;
    tag = "R2";
    if (ctl[0] && neg && !ctl[1]) tag = "R8";
    else if (ctl[0]) begin
      if (scs || vt) tag = "R9";
      else begin
        for (int i = 0; i < 8; i++)
          if (sh_en[i] && sh_sz[i] >= 4 &&
              ((64'(a) >> (sh_sz[i] + 1)) == (64'(sh_base[i]) >> (sh_sz[i] + 1))))
            w = i;
        if (w >= 0) begin
          x = sh_xn[w]; p = ap_ok(sh_ap[w], priv, kind == 1); tag = "R4";
        end else if (ctl[2]) begin
          p = priv; tag = "R6";
        end else begin
          p = 0; tag = "R7";
        end
      end
    end
    if (kind == 2 && x) begin p = 0; tag = "R10"; end
  endfunction

  task automatic access(input logic [31:0] a, input bit priv, input int kind, input bit neg,
                        input bit ep, input bit ex, input string tag);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_priv = priv; acc_kind = 2'(kind); acc_negpri = neg;
    #1;
    chk(acc_permit === ep, tag, 32'(acc_permit), 32'(ep));
    chk(acc_xn === ex, {tag, "/R10 xn"}, 32'(acc_xn), 32'(ex));
    @(posedge clk);
    #1;
    chk(acc_fault_q === !ep, "R11", 32'(acc_fault_q), 32'(!ep));
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] addrs [14];
    bit p, x;
    string tg;
    addrs = '{32'h0000_0100, 32'h0000_0500, 32'h0800_1000, 32'h2000_0010, 32'h2000_8010,
              32'h2000_8820, 32'h2000_FFFC, 32'h2001_0000, 32'h4000_0004, 32'h6000_0000,
              32'h7000_0000, 32'hE000_E010, 32'hE000_1000, 32'hF000_0000};
    for (int i = 0; i < 8; i++) begin
      sh_base[i] = '0; sh_en[i] = 0; sh_sz[i] = 0; sh_ap[i] = 0; sh_xn[i] = 0;
    end
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    acc_valid = 1'b0; acc_addr = '0; acc_priv = 1'b0; acc_kind = '0; acc_negpri = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_chk(2'd0, 32'h0, "R1 ctrl reset");
    rd_chk(2'd1, 32'h0, "R1 select reset");
    rd_chk(2'd2, 32'h0, "R1 base reset");
    rd_chk(2'd3, 32'h0, "R1 attr reset");
    chk(acc_fault_q === 1'b0, "R11 reset", 32'(acc_fault_q), 32'h0);

    // R2 disabled: everything passes
    access(32'h3000_0000, 0, 1, 0, 1, 0, "R2");

    // R5 permission codes, region 0 at 0x10000000, 1 KB
    wr(2'd0, 32'h1);
    for (int ap = 0; ap < 8; ap++) begin
      set_rgn(0, 32'h1000_0000, 1, 9, ap, 0);
      for (int pv = 0; pv < 2; pv++)
        for (int k = 0; k < 3; k++)
          access(32'h1000_0040, pv[0], k, 0, ap_ok(ap, pv[0], k == 1), 0, "R5");
    end
    // R3 size edge and minimum size
    access(32'h1000_03FC, 0, 0, 0, 0, 0, "R3 inside last word");
    set_rgn(0, 32'h1000_0000, 1, 9, 3, 0);
    access(32'h1000_03FC, 0, 0, 0, 1, 0, "R3 inside last word");
    access(32'h1000_0400, 1, 0, 0, 0, 0, "R3 just past end");
    set_rgn(0, 32'h1000_0000, 1, 3, 3, 0);
    access(32'h1000_0000, 1, 0, 0, 0, 0, "R3 size below minimum");
    // R10 fetch from xn region
    set_rgn(0, 32'h1000_0000, 1, 9, 3, 1);
    access(32'h1000_0000, 1, 2, 0, 0, 1, "R10 fetch xn region");
    access(32'h1000_0000, 1, 0, 0, 1, 1, "R10 read xn region");

    // full configuration
    set_rgn(0, 32'h2000_0000, 1, 15, 3, 0);
    set_rgn(1, 32'h2000_8000, 1, 11, 6, 1);
    set_rgn(2, 32'h4000_0000, 1, 19, 1, 1);
    set_rgn(3, 32'h0800_0000, 1, 17, 5, 0);
    set_rgn(4, 32'h6000_0000, 1, 3, 3, 0);
    set_rgn(5, 32'h7000_0000, 0, 9, 3, 0);
    set_rgn(6, 32'h2000_8800, 1, 7, 0, 0);
    set_rgn(7, 32'hE000_0000, 1, 27, 2, 0);

    // R1 readback through the select
    for (int i = 0; i < 8; i++) begin
      wr(2'd1, 32'(i));
      rd_chk(2'd1, 32'(i), "R1 select readback");
      rd_chk(2'd2, sh_base[i], "R1 base readback");
      rd_chk(2'd3, attr_word(sh_en[i], sh_sz[i], sh_ap[i], sh_xn[i]), "R1 attr readback");
    end
    wr(2'd0, 32'h5);
    rd_chk(2'd0, 32'h5, "R1 ctrl readback");

    // sweep of control bits, privilege, priority, kind, address
    for (int c = 0; c < 8; c++) begin
      wr(2'd0, 32'(c));
      for (int pv = 0; pv < 2; pv++)
        for (int ng = 0; ng < 2; ng++)
          for (int k = 0; k < 3; k++)
            for (int ai = 0; ai < 14; ai++) begin
              ref_model(addrs[ai], pv[0], k, ng[0], 3'(c), p, x, tg);
              access(addrs[ai], pv[0], k, ng[0], p, x, tg);
            end
    end

    // R11 idle cycle after a faulting access
    wr(2'd0, 32'h1);
    access(32'h2001_0000, 1, 0, 0, 0, 0, "R7");
    @(negedge clk);
    acc_valid = 1'b0;
    @(posedge clk);
    #1;
    chk(acc_fault_q === 1'b0, "R11 idle", 32'(acc_fault_q), 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule